// File: doc/BRIEF.md
# PCIe Transmit Flow-Control Credit Tracker

This block tells the transmit side of a PCIe application whether a packet can go out now. For each of the three flow-control classes (posted, non-posted and completion) it keeps one header counter and one data counter of credits consumed. Two sources feed each counter. The first is the application's own packet issue. The second is a hard protocol engine that answers reads and reports errors on its own, and it signals each credit it uses with a single-cycle pulse. The block adds the two sources together, so the counters hold the true total.

Credit limits reach the block on a shared header-limit bus and a shared data-limit bus. The block drives a class select that steps through the three classes, and it latches each class's limits one cycle after selecting that class. A per-type infinite flag makes the send check ignore the counters for that type. Everything is held at zero while the data link is down.

The send check is combinational from the registered state. The caller presents the number of header and data credits its next packet needs and reads one allowed bit per class.

Top module: `pcie_tx_credit_tracker`

## Requirements
- R1: While `link_up` is high, `lim_sel` advances 2'b00 → 2'b01 → 2'b10 → 2'b00 on each clock. While `link_up` is low it is held at 2'b00. The value 2'b11 never appears.
- R2: The values on `lim_hdr` and `lim_data` during a cycle in which `lim_sel` shows class c become class c's limits. With no consumption, the available header credits equal the 8-bit header limit and the available data credits equal the 12-bit data limit.
- R3: Each type's counter adds that type's `app_consume` bit and its `eng_consume` bit. If both are set in the same cycle, the counter advances by two.
- R4: Consumption vectors and infinite flags share one bit encoding: bit 5 posted header, bit 4 posted data, bit 3 non-posted header, bit 2 non-posted data, bit 1 completion header, bit 0 completion data.
- R5: Header counters are 8 bits wide and data counters are 12 bits wide. Both wrap modulo their width, and available credit is (limit − consumed) modulo 2^width.
- R6: `send_ok[c]` is high only when available header credits ≥ `req_hdr` and available data credits ≥ `req_data` for class c. The index c is the class code: 0 posted, 1 non-posted, 2 completion.
- R7: A set infinite flag makes that type's comparison pass, whatever the counter and request values.
- R8: While `link_up` is low, every `send_ok` bit is low, and counters, latched limits and flags are cleared. Consumption pulses that arrive while the link is down are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Data link is up |
| app_consume | input | 6 | Credits consumed by application packets this cycle |
| eng_consume | input | 6 | Single-cycle credit pulses from the protocol engine |
| lim_sel | output | 2 | Class whose limits are wanted on the limit buses |
| lim_hdr | input | 8 | Header credit limit of the selected class |
| lim_data | input | 12 | Data credit limit of the selected class |
| lim_inf | input | 6 | Per-type infinite-credit flags |
| req_hdr | input | 8 | Header credits needed by the next packet |
| req_data | input | 12 | Data credits needed by the next packet |
| send_ok | output | 3 | Per-class send allowed |

## Verification
Application issue and engine pulses can land on the same credit type in the same cycle. If they do, the counter must advance by two and neither source may be lost. The bench sweeps every legal application pattern against every legal engine pattern (nothing, a header alone, or a header with its data, in each class), which covers overlap on the same type as well as on different classes. After each pair it computes the available credits arithmetically and probes `send_ok` exactly at the available amount and one credit above it. A dropped or doubled pulse therefore changes a pass or fail decision.

// File: rtl/pcie_txcr_pkg.sv
package pcie_txcr_pkg;
  localparam int NUM_CLS   = 3;
  localparam int NUM_TYPES = 2 * NUM_CLS;

  typedef enum logic [1:0] {
    CLS_POST = 2'b00,
    CLS_NONP = 2'b01,
    CLS_CPL  = 2'b10
  } cr_cls_e;

  // bit index of a class's header / data type in a 6-bit type vector
  function automatic int hdr_idx(input int cls);
    return NUM_TYPES - 1 - 2 * cls;
  endfunction

  function automatic int dat_idx(input int cls);
    return NUM_TYPES - 2 - 2 * cls;
  endfunction
endpackage

// File: rtl/pcie_txcr_counter.sv
module pcie_txcr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_up,
  input  logic         inc_a,
  input  logic         inc_b,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = !link_up || inc_a || inc_b;
    if (!link_up)
      cnt_d = '0;
    else
      cnt_d = cnt_q + {{(W-1){1'b0}}, inc_a} + {{(W-1){1'b0}}, inc_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pcie_txcr_limits.sv
module pcie_txcr_limits
  import pcie_txcr_pkg::*;
#(
  parameter int HW = 8,
  parameter int DW = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_up,
  input  logic [HW-1:0]                 lim_hdr,
  input  logic [DW-1:0]                 lim_data,
  input  logic [NUM_TYPES-1:0]          lim_inf,
  output logic [1:0]                    sel,
  output logic [NUM_CLS-1:0][HW-1:0]    lim_h,
  output logic [NUM_CLS-1:0][DW-1:0]    lim_d,
  output logic [NUM_TYPES-1:0]          inf
);
  localparam logic [1:0] LAST_SEL = 2'(NUM_CLS - 1);

  logic [1:0]                 sel_q, sel_d;
  logic                       cap_vld_q, cap_vld_d;
  logic [1:0]                 cap_cls_q, cap_cls_d;
  logic [HW-1:0]              cap_h_q, cap_h_d;
  logic [DW-1:0]              cap_d_q, cap_d_d;
  logic [NUM_CLS-1:0][HW-1:0] tab_h_q, tab_h_d;
  logic [NUM_CLS-1:0][DW-1:0] tab_d_q, tab_d_d;
  logic [NUM_CLS-1:0]         tab_en;
  logic [NUM_TYPES-1:0]       inf_q, inf_d;

  // select sequencer and capture stage
  always_comb begin
    if (!link_up)
      sel_d = 2'b00;
    else if (sel_q == LAST_SEL)
      sel_d = 2'b00;
    else
      sel_d = sel_q + 2'd1;
    cap_vld_d = link_up;
    cap_cls_d = sel_q;
    cap_h_d   = lim_hdr;
    cap_d_d   = lim_data;
    inf_d     = link_up ? lim_inf : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 2'b00;
      cap_vld_q <= 1'b0;
      cap_cls_q <= 2'b00;
      cap_h_q   <= '0;
      cap_d_q   <= '0;
      inf_q     <= '0;
    end else begin
      sel_q     <= sel_d;
      cap_vld_q <= cap_vld_d;
      cap_cls_q <= cap_cls_d;
      cap_h_q   <= cap_h_d;
      cap_d_q   <= cap_d_d;
      inf_q     <= inf_d;
    end
  end

  // per-class limit table
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_tab
    always_comb begin
      tab_en[c] = !link_up || (cap_vld_q && (cap_cls_q == 2'(c)));
      if (!link_up) begin
        tab_h_d[c] = '0;
        tab_d_d[c] = '0;
      end else begin
        tab_h_d[c] = cap_h_q;
        tab_d_d[c] = cap_d_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_h_q[c] <= '0;
        tab_d_q[c] <= '0;
      end else if (tab_en[c]) begin
        tab_h_q[c] <= tab_h_d[c];
        tab_d_q[c] <= tab_d_d[c];
      end
    end
  end

  assign sel   = sel_q;
  assign lim_h = tab_h_q;
  assign lim_d = tab_d_q;
  assign inf   = inf_q;
endmodule

// File: rtl/pcie_txcr_check.sv
module pcie_txcr_check #(
  parameter int HW = 8,
  parameter int DW = 12
) (
  input  logic          link_up,
  input  logic [HW-1:0] lim_h,
  input  logic [HW-1:0] cnt_h,
  input  logic          inf_h,
  input  logic [DW-1:0] lim_d,
  input  logic [DW-1:0] cnt_d,
  input  logic          inf_d,
  input  logic [HW-1:0] req_h,
  input  logic [DW-1:0] req_d,
  output logic          ok
);
  logic [HW-1:0] avail_h;
  logic [DW-1:0] avail_d;
  logic          hdr_fit, dat_fit;

  always_comb begin
    avail_h = lim_h - cnt_h;
    avail_d = lim_d - cnt_d;
    hdr_fit = inf_h || (avail_h >= req_h);
    dat_fit = inf_d || (avail_d >= req_d);
    ok      = link_up && hdr_fit && dat_fit;
  end
endmodule

// File: rtl/pcie_tx_credit_tracker.sv
module pcie_tx_credit_tracker
  import pcie_txcr_pkg::*;
#(
  parameter int HW = 8,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic [NUM_TYPES-1:0] app_consume,
  input  logic [NUM_TYPES-1:0] eng_consume,
  output logic [1:0]           lim_sel,
  input  logic [HW-1:0]        lim_hdr,
  input  logic [DW-1:0]        lim_data,
  input  logic [NUM_TYPES-1:0] lim_inf,
  input  logic [HW-1:0]        req_hdr,
  input  logic [DW-1:0]        req_data,
  output logic [NUM_CLS-1:0]   send_ok
);
  logic [NUM_CLS-1:0][HW-1:0] lim_h, cnt_h;
  logic [NUM_CLS-1:0][DW-1:0] lim_d, cnt_d;
  logic [NUM_TYPES-1:0]       inf_q;

  pcie_txcr_limits #(.HW(HW), .DW(DW)) u_limits (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_up  (link_up),
    .lim_hdr  (lim_hdr),
    .lim_data (lim_data),
    .lim_inf  (lim_inf),
    .sel      (lim_sel),
    .lim_h    (lim_h),
    .lim_d    (lim_d),
    .inf      (inf_q)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam int HB = hdr_idx(c);
    localparam int DB = dat_idx(c);

    pcie_txcr_counter #(.W(HW)) u_cnt_h (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .inc_a   (app_consume[HB]),
      .inc_b   (eng_consume[HB]),
      .cnt     (cnt_h[c])
    );

    pcie_txcr_counter #(.W(DW)) u_cnt_d (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .inc_a   (app_consume[DB]),
      .inc_b   (eng_consume[DB]),
      .cnt     (cnt_d[c])
    );

    pcie_txcr_check #(.HW(HW), .DW(DW)) u_chk (
      .link_up (link_up),
      .lim_h   (lim_h[c]),
      .cnt_h   (cnt_h[c]),
      .inf_h   (inf_q[HB]),
      .lim_d   (lim_d[c]),
      .cnt_d   (cnt_d[c]),
      .inf_d   (inf_q[DB]),
      .req_h   (req_hdr),
      .req_d   (req_data),
      .ok      (send_ok[c])
    );
  end
endmodule

// File: rtl/pcie_tx_credit_tracker_sva.sv
module pcie_tx_credit_tracker_sva
  import pcie_txcr_pkg::*;
#(
  parameter int HW = 8,
  parameter int DW = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       link_up,
  input logic [1:0]                 lim_sel,
  input logic [NUM_CLS-1:0]         send_ok,
  input logic [NUM_CLS-1:0][HW-1:0] cnt_h,
  input logic [NUM_CLS-1:0][DW-1:0] cnt_d,
  input logic [NUM_TYPES-1:0]       inf_q
);
  // R1: select never shows the unused code
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lim_sel != 2'b11);

  // R1: stepping order while the link is up
  p_sel_step0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && lim_sel == 2'b00) |=> lim_sel == 2'b01);
  p_sel_step1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && lim_sel == 2'b01) |=> lim_sel == 2'b10);
  p_sel_step2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && lim_sel == 2'b10) |=> lim_sel == 2'b00);

  // R8: link down blocks all sends
  p_down_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> send_ok == '0);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_a
    // R3: two sources at most advance a counter by two per cycle
    p_hdr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> (HW'(cnt_h[c] - $past(cnt_h[c])) <= HW'(2)));
    p_dat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> (DW'(cnt_d[c] - $past(cnt_d[c])) <= DW'(2)));
    // R8: counters cleared after link down
    p_down_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (cnt_h[c] == '0 && cnt_d[c] == '0));
    // R7: both types infinite means the class may always send
    p_inf_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && inf_q[hdr_idx(c)] && inf_q[dat_idx(c)]) |-> send_ok[c]);
  end
endmodule

bind pcie_tx_credit_tracker pcie_tx_credit_tracker_sva #(.HW(HW), .DW(DW)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .link_up (link_up),
  .lim_sel (lim_sel),
  .send_ok (send_ok),
  .cnt_h   (cnt_h),
  .cnt_d   (cnt_d),
  .inf_q   (inf_q)
);

// File: tb/pcie_tx_credit_tracker_tb.sv
module pcie_tx_credit_tracker_tb;
  logic        clk, rst_n, link_up;
  logic [5:0]  app_consume, eng_consume, lim_inf;
  logic [1:0]  lim_sel;
  logic [7:0]  lim_hdr, req_hdr;
  logic [11:0] lim_data, req_data;
  logic [2:0]  send_ok;

  int lh[3], ld[3];
  int cons[6];
  logic [5:0] inf_m;
  int n_tests, n_fail;

  pcie_tx_credit_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .app_consume(app_consume), .eng_consume(eng_consume),
    .lim_sel(lim_sel), .lim_hdr(lim_hdr), .lim_data(lim_data),
    .lim_inf(lim_inf), .req_hdr(req_hdr), .req_data(req_data),
    .send_ok(send_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // external limit mux, driven from the select
  always_comb begin
    case (lim_sel)
      2'b01:   begin lim_hdr = 8'(lh[1]); lim_data = 12'(ld[1]); end
      2'b10:   begin lim_hdr = 8'(lh[2]); lim_data = 12'(ld[2]); end
      default: begin lim_hdr = 8'(lh[0]); lim_data = 12'(ld[0]); end
    endcase
  end
  assign lim_inf = inf_m;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1: sequence check while settling
  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      int prev = int'(lim_sel);
      tick();
      chk(int'(lim_sel) == (prev + 1) % 3, "R1 select step", lim_sel, (prev + 1) % 3);
    end
  endtask

  task automatic pulse(input logic [5:0] a, input logic [5:0] e);
    app_consume = a;
    eng_consume = e;
    tick();
    app_consume = '0;
    eng_consume = '0;
    if (link_up)
      for (int t = 0; t < 6; t++) begin
        cons[t] += int'(a[t]) + int'(e[t]);
        cons[t] = cons[t] % (((t % 2) == 1) ? 256 : 4096);
      end
  endtask

  task automatic probe(input int c, input int rh, input int rd, input bit exp, input string tag);
    req_hdr  = 8'(rh);
    req_data = 12'(rd);
    #1;
    chk(send_ok[c] == exp, tag, send_ok[c], exp);
  endtask

  // R5/R6/R7: boundary probes per class from the arithmetic model
  task automatic check_cls(input int c);
    int hb = 5 - 2 * c;
    int db = 4 - 2 * c;
    int ah = ((lh[c] - cons[hb]) % 256 + 256) % 256;
    int ad = ((ld[c] - cons[db]) % 4096 + 4096) % 4096;
    probe(c, ah, ad, 1'b1, "R6 exact fit");
    if (inf_m[hb]) probe(c, 255, 0, 1'b1, "R7 hdr infinite");
    else if (ah < 255) probe(c, ah + 1, 0, 1'b0, "R6 hdr short by one");
    if (inf_m[db]) probe(c, 0, 4095, 1'b1, "R7 data infinite");
    else if (ad < 4095) probe(c, 0, ad + 1, 1'b0, "R6 data short by one");
  endtask

  task automatic check_all();
    for (int c = 0; c < 3; c++) check_cls(c);
  endtask

  function automatic logic [5:0] pat(input int k);
    // 0 none; 1..3 header of class k-1; 4..6 header+data of class k-4
    if (k == 0) return 6'b0;
    if (k <= 3) return 6'(1) << (5 - 2 * (k - 1));
    return 6'(3) << (4 - 2 * (k - 4));
  endfunction

  task automatic link_cycle();
    link_up = 1'b0;
    tick();
    for (int t = 0; t < 6; t++) cons[t] = 0;
    link_up = 1'b1;
    tick();
    settle(6);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_up = 1'b0;
    app_consume = '0; eng_consume = '0; inf_m = '0;
    req_hdr = '0; req_data = '0;
    lh = '{20, 7, 3}; ld = '{100, 50, 9};
    for (int t = 0; t < 6; t++) cons[t] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(send_ok == 3'b000, "R8 reset send_ok", send_ok, 0);
    chk(lim_sel == 2'b00, "R1 reset select", lim_sel, 0);
    rst_n = 1'b1;
    tick();
    chk(lim_sel == 2'b00, "R1 held while down", lim_sel, 0);

    link_up = 1'b1;
    tick();
    settle(6);
    // R2: limits captured, nothing consumed
    check_all();

    // R3/R4: sweep application against engine patterns
    for (int a = 0; a < 7; a++)
      for (int e = 0; e < 7; e++) begin
        pulse(pat(a), pat(e));
        check_all();
      end

    // R7: infinite flags, one type at a time and whole classes
    for (int t = 0; t < 6; t++) begin
      inf_m = 6'(1) << t;
      tick();
      check_all();
    end
    inf_m = 6'b110000;
    tick();
    probe(0, 255, 4095, 1'b1, "R7 posted infinite");
    inf_m = '0;
    tick();

    // R8: link down blocks, clears, and ignores pulses
    link_up = 1'b0;
    tick();
    probe(0, 0, 0, 1'b0, "R8 down posted");
    probe(2, 0, 0, 1'b0, "R8 down completion");
    chk(lim_sel == 2'b00, "R8 select held", lim_sel, 0);
    for (int t = 0; t < 6; t++) cons[t] = 0;
    pulse(6'b111111, 6'b111111);
    lh = '{200, 17, 255}; ld = '{4095, 1, 0};
    link_up = 1'b1;
    tick();
    settle(6);
    check_all();

    // R5: header wrap on posted header, both sources together
    link_cycle();
    lh[0] = 10;
    settle(3);
    for (int i = 0; i < 130; i++) pulse(6'b100000, 6'b100000);
    check_all();
    // R5: data wrap on completion data
    link_cycle();
    for (int i = 0; i < 2050; i++) pulse(6'b000011, 6'b000011);
    check_all();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule